// File: doc/BRIEF.md
# DRAM Stress Test Sequencer

This block is a built-in self-test engine placed in front of a banked DRAM-style memory. It talks to the memory through a plain request port: one address, one write-data word, a read strobe, a write strobe, and a read-data word with its own valid flag. The engine heats one bank with reads that change row on every access. It then writes and verifies a set of data templates, page by page, in that bank, and only then moves on to the next bank.

Before it verifies a page, the engine reads another row of the same bank. The row buffer then no longer holds the written data, and the check must come from the cell array. These away reads also set a programmable delay between the last write and the first check, which exposes cells that lose their charge too early. Extra idle reads are placed between verify reads to keep the memory busy.

Each template pass visits the rows of a bank twice. The first round is in ascending order and the second follows a repeatable pseudo-random sequence. The engine stops at the first mismatch and holds the address, the expected word and the word read back. The bank count, the page length, the warm-up length and the verify delay are set at each start.

Top module: `dstress_bist`

## Requirements
- R1: After reset, `done` and `fail` are 0, `fail_addr`, `fail_exp` and `fail_act` are 0, and neither `mem_re` nor `mem_we` is asserted.
- R2: `mem_re` and `mem_we` are never high in the same cycle. After a read request, no further request is issued until `mem_rvalid` has returned, and the reply may arrive any number of cycles later.
- R3: Memory addresses are laid out as {row, bank, column}, with the column in the low COL_W bits and the bank just above it. Each bank begins with `cfg_warm_iters` reads at column 0 of that bank, where warm read i uses row i mod ROWS. When `cfg_warm_iters` is 0, the warm-up is skipped.
- R4: Banks are exercised one at a time, in ascending order from bank 0 to bank `cfg_banks`-1. No request of a bank is issued after a request to a higher bank.
- R5: Four templates run in this order: 0x55..55 (even bits set), 0xAA..AA, the address repeated across the word (address bit i mod ADDR_W lands in data bit i), and the bitwise inverse of that. `mem_wdata` carries the template word for the written address.
- R6: A page visit writes columns 0 to page-1 of row r in ascending order. It then issues max(1, `cfg_delay`) reads at column 0 of row (r+1) mod ROWS in the same bank, and then reads columns 0 to page-1 of row r in ascending order and compares each word.
- R7: After every IDLE_GAP-th verify read of a page, except the last read of the page, one idle read is issued to column 0 of row (r+1) mod ROWS.
- R8: For each template, the rows 0 to ROWS-1 are first visited in order. Then ROWS more visits follow, each using the low ROW_W bits of a 16-bit shift register. The register is loaded with 0xACE1 at start, shifts left with new bit s15^s13^s12^s10 just before each such visit, and runs on across templates and banks.
- R9: On the first verify mismatch, the engine stops issuing requests and sets `done` and `fail`. It latches the address, the expected word and the returned word, and all of these hold until the next start.
- R10: When every template has passed in every bank, `done` is 1, `fail` is 0, the failure fields stay 0, and no further request is issued.
- R11: A `start` accepted while the engine is not running samples the configuration, clears `done`, `fail` and the failure fields, and begins at bank 0. A bank count or page length of 0 is treated as 1, and values above the maximum are cut to the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test run (ignored while running) |
| cfg_banks | input | BANK_W+1 | Number of banks to test |
| cfg_page_len | input | COL_W+1 | Words per page |
| cfg_warm_iters | input | WARM_W | Warm-up reads per bank |
| cfg_delay | input | DLY_W | Away reads before verifying a page |
| mem_addr | output | ADDR_W | Request address {row, bank, column} |
| mem_wdata | output | DATA_W | Write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | DATA_W | Read data, valid with mem_rvalid |
| mem_rvalid | input | 1 | Read reply valid |
| done | output | 1 | Run finished (pass or fail) |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word at the first mismatch |
| fail_act | output | DATA_W | Returned word at the first mismatch |

## Verification
The checks assume that the memory raises `mem_rvalid` exactly once for each read strobe and never without one. They also assume that `start` is pulsed only while the engine is idle or finished. The bench memory replies one cycle after each read strobe, and `start` is driven only after `done` or right after reset. Faults are placed in that bench memory: a stuck-at-1 bit, a stuck-at-0 bit and a column alias. Each one appears only under a particular template, so the bench can predict which address and word pair is reported.

// File: rtl/dstress_pkg.sv
package dstress_pkg;

    typedef enum logic [2:0] {
        PH_WARM,
        PH_WRITE,
        PH_AWAY,
        PH_CHECK,
        PH_IDLE
    } phase_e;

    typedef enum logic [1:0] {
        TPL_ALT,
        TPL_ALT_N,
        TPL_ADDR,
        TPL_ADDR_N
    } tpl_e;

    localparam int               LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    // Fibonacci shift-left step, taps 16/14/13/11
    function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic phase_reads(input phase_e p);
        return p != PH_WRITE;
    endfunction

endpackage

// File: rtl/dstress_lfsr.sv
module dstress_lfsr
    import dstress_pkg::*;
#(
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             step,
    output logic [OUT_W-1:0] row_nxt
);
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_nxt;

    assign state_nxt = lfsr_adv(state_q);
    assign row_nxt   = state_nxt[OUT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || load) begin
            state_q <= LFSR_SEED;
        end else if (step) begin
            state_q <= state_nxt;
        end
    end
endmodule

// File: rtl/dstress_pattern.sv
module dstress_pattern
    import dstress_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  tpl_e              tpl,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] alt_w;
    logic [DATA_W-1:0] rep_w;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign alt_w[i] = ((i % 2) == 0) ? 1'b1 : 1'b0;
        assign rep_w[i] = addr[i % ADDR_W];
    end

    always_comb begin
        unique case (tpl)
            TPL_ALT:    data = alt_w;
            TPL_ALT_N:  data = ~alt_w;
            TPL_ADDR:   data = rep_w;
            TPL_ADDR_N: data = ~rep_w;
            default:    data = alt_w;
        endcase
    end
endmodule

// File: rtl/dstress_capture.sv
module dstress_capture #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              chk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] exp_w,
    input  logic [DATA_W-1:0] act_w,
    output logic              miss,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_act
);
    assign miss = chk && (exp_w != act_w);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (miss && !fail) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_exp  <= exp_w;
            fail_act  <= act_w;
        end
    end
endmodule

// File: rtl/dstress_bist.sv
module dstress_bist
    import dstress_pkg::*;
#(
    parameter int ROW_W    = 3,
    parameter int BANK_W   = 2,
    parameter int COL_W    = 3,
    parameter int DATA_W   = 16,
    parameter int WARM_W   = 16,
    parameter int DLY_W    = 8,
    parameter int IDLE_GAP = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [BANK_W:0]            cfg_banks,
    input  logic [COL_W:0]             cfg_page_len,
    input  logic [WARM_W-1:0]          cfg_warm_iters,
    input  logic [DLY_W-1:0]           cfg_delay,
    output logic [ROW_W+BANK_W+COL_W-1:0] mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    output logic                       mem_we,
    output logic                       mem_re,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_rvalid,
    output logic                       done,
    output logic                       fail,
    output logic [ROW_W+BANK_W+COL_W-1:0] fail_addr,
    output logic [DATA_W-1:0]          fail_exp,
    output logic [DATA_W-1:0]          fail_act
);
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int GAP_W  = $clog2(IDLE_GAP + 1);
    localparam logic [BANK_W:0] BANK_MAX = (BANK_W+1)'(1 << BANK_W);
    localparam logic [COL_W:0]  PAGE_MAX = (COL_W+1)'(1 << COL_W);

    // run state
    logic               running;
    logic               waiting;
    logic               done_q;
    phase_e             phase;
    tpl_e               tpl_q;
    logic               pass_q;
    logic [BANK_W-1:0]  bank_q;
    logic [ROW_W-1:0]   visit_q;
    logic [ROW_W-1:0]   row_q;
    logic [COL_W-1:0]   col_q;
    logic [WARM_W-1:0]  cnt_q;
    logic [DLY_W-1:0]   dly_cnt;
    logic [GAP_W-1:0]   gap_q;

    // configuration sampled at start
    logic [BANK_W:0]    banks_q;
    logic [COL_W:0]     page_q;
    logic [WARM_W-1:0]  warm_q;
    logic [DLY_W-1:0]   dly_q;

    logic [ROW_W-1:0]   rsel;
    logic [COL_W-1:0]   csel;
    logic [DATA_W-1:0]  tpl_word;
    logic               start_acc, issue, is_rd, rsp, check_rsp, miss;
    logic               col_last, bank_last, warm_last, dly_last, gap_hit;
    logic               visit_full, visit_end, lfsr_step;
    logic [ROW_W-1:0]   rnd_row;

    function automatic logic [BANK_W:0] clamp_banks(input logic [BANK_W:0] v);
        if (v == '0)      return (BANK_W+1)'(1);
        if (v > BANK_MAX) return BANK_MAX;
        return v;
    endfunction

    function automatic logic [COL_W:0] clamp_page(input logic [COL_W:0] v);
        if (v == '0)      return (COL_W+1)'(1);
        if (v > PAGE_MAX) return PAGE_MAX;
        return v;
    endfunction

    assign start_acc = start && !running;
    assign is_rd     = phase_reads(phase);
    assign issue     = running && !waiting;
    assign rsp       = running && waiting && mem_rvalid;
    assign check_rsp = rsp && (phase == PH_CHECK);

    assign col_last   = ({1'b0, col_q} + (COL_W+1)'(1)) == page_q;
    assign bank_last  = ({1'b0, bank_q} + (BANK_W+1)'(1)) == banks_q;
    assign warm_last  = (cnt_q + WARM_W'(1)) == warm_q;
    assign dly_last   = (dly_cnt + DLY_W'(1)) == dly_q;
    assign gap_hit    = (gap_q + GAP_W'(1)) == GAP_W'(IDLE_GAP);
    assign visit_full = &visit_q;
    assign visit_end  = check_rsp && !miss && col_last;
    assign lfsr_step  = visit_end && (pass_q ? !visit_full : visit_full);

    // request address selection
    always_comb begin
        rsel = row_q;
        csel = col_q;
        unique case (phase)
            PH_WARM: begin
                rsel = cnt_q[ROW_W-1:0];
                csel = '0;
            end
            PH_AWAY, PH_IDLE: begin
                rsel = row_q + ROW_W'(1);
                csel = '0;
            end
            default: ;
        endcase
    end

    assign mem_addr  = {rsel, bank_q, csel};
    assign mem_re    = issue && is_rd;
    assign mem_we    = issue && !is_rd;
    assign mem_wdata = tpl_word;
    assign done      = done_q;

    dstress_pattern #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pattern (
        .tpl  (tpl_q),
        .addr ({row_q, bank_q, col_q}),
        .data (tpl_word)
    );

    dstress_lfsr #(
        .OUT_W (ROW_W)
    ) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load    (start_acc),
        .step    (lfsr_step),
        .row_nxt (rnd_row)
    );

    dstress_capture #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_acc),
        .chk       (check_rsp),
        .addr      (mem_addr),
        .exp_w     (tpl_word),
        .act_w     (mem_rdata),
        .miss      (miss),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_exp  (fail_exp),
        .fail_act  (fail_act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            waiting <= 1'b0;
            done_q  <= 1'b0;
            phase   <= PH_WARM;
            tpl_q   <= TPL_ALT;
            pass_q  <= 1'b0;
            bank_q  <= '0;
            visit_q <= '0;
            row_q   <= '0;
            col_q   <= '0;
            cnt_q   <= '0;
            dly_cnt <= '0;
            gap_q   <= '0;
            banks_q <= (BANK_W+1)'(1);
            page_q  <= (COL_W+1)'(1);
            warm_q  <= '0;
            dly_q   <= DLY_W'(1);
        end else if (start_acc) begin
            running <= 1'b1;
            waiting <= 1'b0;
            done_q  <= 1'b0;
            phase   <= (cfg_warm_iters == '0) ? PH_WRITE : PH_WARM;
            tpl_q   <= TPL_ALT;
            pass_q  <= 1'b0;
            bank_q  <= '0;
            visit_q <= '0;
            row_q   <= '0;
            col_q   <= '0;
            cnt_q   <= '0;
            dly_cnt <= '0;
            gap_q   <= '0;
            banks_q <= clamp_banks(cfg_banks);
            page_q  <= clamp_page(cfg_page_len);
            warm_q  <= cfg_warm_iters;
            dly_q   <= (cfg_delay == '0) ? DLY_W'(1) : cfg_delay;
        end else if (running) begin
            if (issue && is_rd) begin
                waiting <= 1'b1;
            end
            if (issue && !is_rd) begin
                if (col_last) begin
                    col_q   <= '0;
                    dly_cnt <= '0;
                    phase   <= PH_AWAY;
                end else begin
                    col_q <= col_q + COL_W'(1);
                end
            end
            if (rsp) begin
                waiting <= 1'b0;
                unique case (phase)
                    PH_WARM: begin
                        if (warm_last) begin
                            cnt_q <= '0;
                            phase <= PH_WRITE;
                        end else begin
                            cnt_q <= cnt_q + WARM_W'(1);
                        end
                    end
                    PH_AWAY: begin
                        if (dly_last) begin
                            phase <= PH_CHECK;
                            col_q <= '0;
                            gap_q <= '0;
                        end else begin
                            dly_cnt <= dly_cnt + DLY_W'(1);
                        end
                    end
                    PH_IDLE: begin
                        phase <= PH_CHECK;
                    end
                    PH_CHECK: begin
                        if (miss) begin
                            running <= 1'b0;
                            done_q  <= 1'b1;
                        end else if (col_last) begin
                            col_q <= '0;
                            phase <= PH_WRITE;
                            if (!visit_full) begin
                                visit_q <= visit_q + ROW_W'(1);
                                row_q   <= pass_q ? rnd_row : (visit_q + ROW_W'(1));
                            end else if (!pass_q) begin
                                pass_q  <= 1'b1;
                                visit_q <= '0;
                                row_q   <= rnd_row;
                            end else begin
                                pass_q  <= 1'b0;
                                visit_q <= '0;
                                row_q   <= '0;
                                if (tpl_q != TPL_ADDR_N) begin
                                    tpl_q <= tpl_e'(tpl_q + 2'd1);
                                end else begin
                                    tpl_q <= TPL_ALT;
                                    cnt_q <= '0;
                                    if (bank_last) begin
                                        running <= 1'b0;
                                        done_q  <= 1'b1;
                                    end else begin
                                        bank_q <= bank_q + BANK_W'(1);
                                        phase  <= (warm_q == '0) ? PH_WRITE : PH_WARM;
                                    end
                                end
                            end
                        end else begin
                            col_q <= col_q + COL_W'(1);
                            if (gap_hit) begin
                                gap_q <= '0;
                                phase <= PH_IDLE;
                            end else begin
                                gap_q <= gap_q + GAP_W'(1);
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dstress_bist_chk.sv
module dstress_bist_chk #(
    parameter int BANK_W = 2,
    parameter int COL_W  = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              running,
    input logic              mem_re,
    input logic              mem_we,
    input logic              mem_rvalid,
    input logic [BANK_W-1:0] req_bank,
    input logic [COL_W-1:0]  req_col,
    input logic [BANK_W:0]   banks_q,
    input logic [COL_W:0]    page_q,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic [DATA_W-1:0] fail_exp,
    input logic [DATA_W-1:0] fail_act
);
    logic              outstanding;
    logic [BANK_W-1:0] last_bank;
    logic              req;

    assign req = mem_re || mem_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding <= 1'b0;
        end else if (mem_re) begin
            outstanding <= 1'b1;
        end else if (mem_rvalid) begin
            outstanding <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || (start && !running)) begin
            last_bank <= '0;
        end else if (req) begin
            last_bank <= req_bank;
        end
    end

    AST_EXCL_CMD: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we)); // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !req); // R2
    AST_BANK_ORDER: assert property (@(posedge clk) disable iff (rst)
        req |-> (req_bank >= last_bank)); // R4
    AST_BANK_RANGE: assert property (@(posedge clk) disable iff (rst)
        req |-> ({1'b0, req_bank} < banks_q)); // R4
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        req |-> ({1'b0, req_col} < page_q)); // R6
    AST_FAIL_IMPLIES_DONE: assert property (@(posedge clk) disable iff (rst)
        fail |-> done); // R9
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(fail) && $stable(fail_addr)
                              && $stable(fail_exp) && $stable(fail_act))); // R9
    AST_QUIET_WHEN_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !req); // R10
endmodule

bind dstress_bist dstress_bist_chk #(
    .BANK_W (BANK_W),
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .running    (running),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_rvalid (mem_rvalid),
    .req_bank   (mem_addr[COL_W +: BANK_W]),
    .req_col    (mem_addr[COL_W-1:0]),
    .banks_q    (banks_q),
    .page_q     (page_q),
    .done       (done),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_exp   (fail_exp),
    .fail_act   (fail_act)
);

// File: tb/tb_dstress_bist.sv
module tb_dstress_bist;
    localparam int ROW_W = 3, BANK_W = 2, COL_W = 3, DATA_W = 16;
    localparam int WARM_W = 16, DLY_W = 8, IDLE_GAP = 3;
    localparam int ADDR_W = ROW_W + BANK_W + COL_W;
    localparam int ROWS = 1 << ROW_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [BANK_W:0]   cfg_banks = '0;
    logic [COL_W:0]    cfg_page_len = '0;
    logic [WARM_W-1:0] cfg_warm_iters = '0;
    logic [DLY_W-1:0]  cfg_delay = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_we, mem_re;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              mem_rvalid = 1'b0;
    logic              done, fail;
    logic [ADDR_W-1:0] fail_addr;
    logic [DATA_W-1:0] fail_exp, fail_act;

    dstress_bist #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .WARM_W(WARM_W), .DLY_W(DLY_W), .IDLE_GAP(IDLE_GAP)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .cfg_banks(cfg_banks),
        .cfg_page_len(cfg_page_len), .cfg_warm_iters(cfg_warm_iters),
        .cfg_delay(cfg_delay), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .mem_rvalid(mem_rvalid), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // memory model with fault injection: 0 none, 1 stuck-1, 2 stuck-0, 3 alias
    logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
    int                flt_mode = 0;
    logic [ADDR_W-1:0] flt_addr = '0;
    logic [ADDR_W-1:0] flt_src = '0;
    logic [DATA_W-1:0] flt_mask = '0;

    function automatic logic [DATA_W-1:0] mem_read(input logic [ADDR_W-1:0] a);
        if (a == flt_addr) begin
            case (flt_mode)
                1: return mem[a] | flt_mask;
                2: return mem[a] & ~flt_mask;
                3: return mem[flt_src];
                default: return mem[a];
            endcase
        end
        return mem[a];
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rvalid <= mem_re;
        if (mem_re) mem_rdata <= mem_read(mem_addr);
    end

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [3:0]        tag;
    } req_t;

    req_t expq[$];
    int   cat_err [0:15];
    bit   mon_en = 1'b0;
    int   extra_reqs, after_done, excl_err, ovl_err, bank_err, last_bank;
    bit   outst;

    function automatic logic [ADDR_W-1:0] mk(input int r, input int b, input int c);
        return {ROW_W'(r), BANK_W'(b), COL_W'(c)};
    endfunction

    function automatic logic [DATA_W-1:0] tpl_word(input int t, input logic [ADDR_W-1:0] a);
        case (t)
            0: return 16'h5555;
            1: return 16'hAAAA;
            2: return {a, a};
            default: return ~{a, a};
        endcase
    endfunction

    task automatic push(input logic we, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input int tag);
        req_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = 4'(tag);
        expq.push_back(e);
    endtask

    // expected request stream, built from R3..R8
    task automatic build(input int nb, input int pg, input int wm, input int dl);
        logic [15:0] lf;
        int r, aw, nd;
        expq.delete();
        lf = 16'hACE1;
        nd = (dl < 1) ? 1 : dl;
        for (int b = 0; b < nb; b++) begin
            for (int i = 0; i < wm; i++) push(1'b0, mk(i % ROWS, b, 0), '0, 3);
            for (int t = 0; t < 4; t++) begin
                for (int p = 0; p < 2; p++) begin
                    for (int k = 0; k < ROWS; k++) begin
                        if (p == 0) r = k;
                        else begin
                            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                            r = int'(lf[ROW_W-1:0]);
                        end
                        aw = (r + 1) % ROWS;
                        for (int c = 0; c < pg; c++) push(1'b1, mk(r, b, c), tpl_word(t, mk(r, b, c)), 5);
                        for (int d = 0; d < nd; d++) push(1'b0, mk(aw, b, 0), '0, (p == 1) ? 8 : 6);
                        for (int c = 0; c < pg; c++) begin
                            push(1'b0, mk(r, b, c), '0, (p == 1) ? 8 : 6);
                            if (((c + 1) % IDLE_GAP == 0) && (c + 1 < pg)) push(1'b0, mk(aw, b, 0), '0, 7);
                        end
                    end
                end
            end
        end
    endtask

    always @(negedge clk) begin
        if (mon_en) begin
            if (mem_rvalid) outst = 1'b0;
            if (mem_re && mem_we) excl_err++;
            if ((mem_re || mem_we) && outst) ovl_err++;
            if (done && (mem_re || mem_we)) after_done++;
            if (mem_re || mem_we) begin
                if (int'(mem_addr[COL_W +: BANK_W]) < last_bank) bank_err++;
                last_bank = int'(mem_addr[COL_W +: BANK_W]);
                if (expq.size() == 0) extra_reqs++;
                else begin
                    req_t e;
                    e = expq.pop_front();
                    if (e.we != mem_we || e.addr != mem_addr || (e.we && e.data != mem_wdata))
                        cat_err[e.tag]++;
                end
            end
            if (mem_re) outst = 1'b1;
        end
    end

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // start one run and wait for done
    task automatic run(input int nb, input int pg, input int wm, input int dl);
        int cb, cp, cyc;
        cb = (nb == 0) ? 1 : ((nb > 4) ? 4 : nb);
        cp = (pg == 0) ? 1 : ((pg > 8) ? 8 : pg);
        build(cb, cp, wm, dl);
        for (int i = 0; i < 16; i++) cat_err[i] = 0;
        extra_reqs = 0; after_done = 0; excl_err = 0; ovl_err = 0;
        bank_err = 0; last_bank = 0; outst = 1'b0;
        @(negedge clk);
        cfg_banks = (BANK_W+1)'(nb); cfg_page_len = (COL_W+1)'(pg);
        cfg_warm_iters = WARM_W'(wm); cfg_delay = DLY_W'(dl);
        mon_en = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R11", "done cleared after start", 32'(done), 32'd0);
        check("R11", "fail cleared after start", 32'(fail), 32'd0);
        check("R11", "fail_addr cleared after start", 32'(fail_addr), 32'd0);
        cyc = 0;
        while (!done && cyc < 60000) begin
            @(negedge clk);
            cyc++;
        end
        check("R10", "run reached done (watchdog)", 32'(done), 32'd1);
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic common_checks();
        check("R2", "read and write together", 32'(excl_err), 32'd0);
        check("R2", "request while read outstanding", 32'(ovl_err), 32'd0);
        check("R3", "warm-up stream errors", 32'(cat_err[3]), 32'd0);
        check("R4", "bank order violations", 32'(bank_err), 32'd0);
        check("R5", "write stream errors", 32'(cat_err[5]), 32'd0);
        check("R6", "away/verify stream errors", 32'(cat_err[6]), 32'd0);
        check("R7", "idle read errors", 32'(cat_err[7]), 32'd0);
        check("R8", "random-pass stream errors", 32'(cat_err[8]), 32'd0);
        check("R9", "requests after done", 32'(after_done), 32'd0);
    endtask

    task automatic pass_checks();
        common_checks();
        check("R10", "fail flag on clean memory", 32'(fail), 32'd0);
        check("R10", "all expected requests issued", 32'(expq.size()), 32'd0);
        check("R10", "no extra requests", 32'(extra_reqs), 32'd0);
        check("R10", "fail_addr stays zero", 32'(fail_addr), 32'd0);
    endtask

    task automatic fail_checks(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e,
                               input logic [DATA_W-1:0] x);
        common_checks();
        check("R9", "fail flag", 32'(fail), 32'd1);
        check("R9", "fail_addr", 32'(fail_addr), 32'(a));
        check("R9", "fail_exp", 32'(fail_exp), 32'(e));
        check("R9", "fail_act", 32'(fail_act), 32'(x));
    endtask

    task automatic t_reset();
        check("R1", "done after reset", 32'(done), 32'd0);
        check("R1", "fail after reset", 32'(fail), 32'd0);
        check("R1", "no request after reset", 32'({mem_re, mem_we}), 32'd0);
        check("R1", "failure fields after reset", 32'({fail_addr, fail_exp} | 40'(fail_act)), 32'd0);
    endtask

    task automatic t_small();
        flt_mode = 0;
        run(1, 4, 3, 1);
        pass_checks();
    endtask

    task automatic t_wide();
        flt_mode = 0;
        run(4, 8, 10, 5);
        pass_checks();
    endtask

    task automatic t_clamp();
        flt_mode = 0;
        run(0, 0, 0, 0);   // R11 zero treated as one, R3 warm-up skipped
        pass_checks();
    endtask

    task automatic t_stuck1();
        flt_mode = 1; flt_addr = mk(2, 1, 1); flt_mask = 16'h0001;
        run(2, 4, 4, 2);
        fail_checks(mk(2, 1, 1), 16'hAAAA, 16'hAAAB);
    endtask

    task automatic t_stuck0();
        flt_mode = 2; flt_addr = mk(0, 0, 0); flt_mask = 16'h0001;
        run(3, 4, 2, 1);
        fail_checks(mk(0, 0, 0), 16'h5555, 16'h5554);
    endtask

    task automatic t_alias();
        flt_mode = 3; flt_addr = mk(1, 0, 2); flt_src = mk(1, 0, 3);
        run(1, 4, 2, 3);
        fail_checks(mk(1, 0, 2), {mk(1, 0, 2), mk(1, 0, 2)}, {mk(1, 0, 3), mk(1, 0, 3)});
    endtask

    task automatic t_restart();
        flt_mode = 0;
        run(2, 5, 1, 2);   // R11 new config after a failed run
        pass_checks();
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_small();
        t_wide();
        t_clamp();
        t_stuck1();
        t_stuck0();
        t_alias();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 190000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule